// File: doc/BRIEF.md
# DMA Channel Request Gating Registers

This block sits in front of the channel arbiter of a 32-channel DMA controller. It keeps three status bits per channel: a request mask, a channel enable and a burst-only selector. It combines these bits with the peripheral single-request lines, the peripheral burst-request lines and the software request strobes. The result is one qualified request vector for the arbiter.

Each status vector has two addresses on a simple memory-mapped bus. Writing a 1 to a bit at the set address sets that bit, and writing a 1 to a bit at the clear address clears it. Writing a 0 never changes a bit. Software therefore updates single channels without a read-modify-write sequence.

A masked channel ignores its peripheral lines. The same channel still accepts software requests while it is enabled. The transfer engine has a separate clear-pulse input that drops enable bits. That pulse wins over a set written in the same cycle.

Top module: `dma_req_gate`

## Requirements
- R1: After reset the mask, enable and burst-only vectors are all 0, so every read-back address returns 0 and `chan_req` is 0.
- R2: A write to offset 0x20 sets every mask bit whose data bit is 1, with bit n belonging to channel n. Bits written 0 keep their value. A read at 0x20 returns the mask vector.
- R3: A mask bit returns to 0 only when a 1 is written to the same bit at offset 0x24. Writes of 0 there, and writes of 0 at 0x20, leave the mask unchanged.
- R4: A 1 written at offset 0x28 sets the enable bit and a 1 written at offset 0x2C clears it. A read at 0x28 returns the enable vector.
- R5: A 1 written at offset 0x18 sets the burst-only bit and a 1 written at offset 0x1C clears it. A read at 0x18 returns the burst-only vector.
- R6: Reads of the clear offsets 0x24, 0x2C and 0x1C return 0, and so do reads of any unmapped offset.
- R7: A 1 on bit n of `en_clr_pulse` clears enable bit n at the next clock edge. This clear wins over a set of the same bit written in the same cycle.
- R8: `chan_req[n]` is 0 whenever enable bit n is 0, whatever the request inputs are.
- R9: On a masked channel the peripheral single and burst lines have no effect. An enabled channel with `sw_req[n]` high always requests.
- R10: When burst-only bit n is 1, `periph_single[n]` is ignored and only `periph_burst[n]` qualifies an unmasked, enabled channel. When the bit is 0, either line qualifies it.
- R11: `chan_req` follows the request inputs within the same cycle. A register write changes `chan_req` only after the clock edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data, one bit per channel |
| bus_rdata | output | 32 | Read data; 0 when there is no read |
| periph_single | input | 32 | Peripheral single-request lines |
| periph_burst | input | 32 | Peripheral burst-request lines |
| sw_req | input | 32 | Software request strobes |
| en_clr_pulse | input | 32 | Enable-clear pulses from the transfer engine |
| chan_req | output | 32 | Qualified request vector to the arbiter |

## Verification
The qualifier is driven with two full truth-table patterns. Together they spread all 64 combinations of mask, enable, burst-only, single, burst and software request across the 32 channels, so an error in any single term appears on a specific channel bit. Further vectors contrast burst-only against mixed operation on the same request lines, an all-masked bank with scattered software strobes, and a disabled bank with every request line active. Directed tests cover writes of zeros at each alias, partial clears, reads of write-only and unmapped offsets, the same-cycle race between the clear pulse and a set write, and the cycle in which a write first changes the request output.

// File: rtl/dma_gate_pkg.sv
package dma_gate_pkg;
  localparam int unsigned CHANS  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_BURST_SET = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_BURST_CLR = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MASK_SET  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK_CLR  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_EN_SET    = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR    = 8'h2C;
endpackage

// File: rtl/w1sc_bank.sv
module w1sc_bank #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;
  logic             upd_en;

  always_comb begin
    upd_en = |(set_vec | clr_vec);
    q_nxt  = (q | set_vec) & ~clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (upd_en) begin
      q <= q_nxt;
    end
  end

  // R3 R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((q & $past(clr_vec)) == '0));

  // R2 R4 R5
  set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & ~clr_vec)) |=> ((q & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(set_vec | clr_vec)) |=> $stable(q));
endmodule

// File: rtl/req_qualifier.sv
module req_qualifier #(
  parameter int unsigned CHANS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CHANS-1:0] mask,
  input  logic [CHANS-1:0] enable,
  input  logic [CHANS-1:0] burst_only,
  input  logic [CHANS-1:0] single_req,
  input  logic [CHANS-1:0] burst_req,
  input  logic [CHANS-1:0] sw_req,
  output logic [CHANS-1:0] req_o
);
  for (genvar n = 0; n < CHANS; n++) begin : g_chan
    logic periph_hit;
    always_comb begin
      periph_hit = burst_req[n] | (single_req[n] & ~burst_only[n]);
      req_o[n]   = enable[n] & (sw_req[n] | (~mask[n] & periph_hit));
    end
  end

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o & ~enable) == '0);

  // R9
  masked_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o & mask & ~sw_req) == '0);

  // R9
  sw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((enable & sw_req) & ~req_o) == '0);

  // R10
  burst_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o & burst_only & ~burst_req & ~sw_req) == '0);
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CHANS-1:0]  bus_wdata,
  output logic [CHANS-1:0]  bus_rdata,
  input  logic [CHANS-1:0]  periph_single,
  input  logic [CHANS-1:0]  periph_burst,
  input  logic [CHANS-1:0]  sw_req,
  input  logic [CHANS-1:0]  en_clr_pulse,
  output logic [CHANS-1:0]  chan_req
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe[SYNC_STAGES-1];

  logic [CHANS-1:0] mask_set, mask_clr, en_set, en_clr, ub_set, ub_clr;
  logic [CHANS-1:0] mask_q, en_q, ub_q;
  logic             wr_acc, rd_acc;

  always_comb begin
    wr_acc   = bus_sel & bus_write;
    rd_acc   = bus_sel & ~bus_write;
    mask_set = (wr_acc && bus_addr == OFS_MASK_SET)  ? bus_wdata : '0;
    mask_clr = (wr_acc && bus_addr == OFS_MASK_CLR)  ? bus_wdata : '0;
    en_set   = (wr_acc && bus_addr == OFS_EN_SET)    ? bus_wdata : '0;
    en_clr   = ((wr_acc && bus_addr == OFS_EN_CLR)   ? bus_wdata : '0) | en_clr_pulse;
    ub_set   = (wr_acc && bus_addr == OFS_BURST_SET) ? bus_wdata : '0;
    ub_clr   = (wr_acc && bus_addr == OFS_BURST_CLR) ? bus_wdata : '0;
  end

  w1sc_bank #(.WIDTH(CHANS)) u_mask (
    .clk(clk), .rst_n(rst_n_int), .set_vec(mask_set), .clr_vec(mask_clr), .q(mask_q)
  );
  w1sc_bank #(.WIDTH(CHANS)) u_enable (
    .clk(clk), .rst_n(rst_n_int), .set_vec(en_set), .clr_vec(en_clr), .q(en_q)
  );
  w1sc_bank #(.WIDTH(CHANS)) u_burst (
    .clk(clk), .rst_n(rst_n_int), .set_vec(ub_set), .clr_vec(ub_clr), .q(ub_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (bus_addr)
        OFS_MASK_SET:  bus_rdata = mask_q;
        OFS_EN_SET:    bus_rdata = en_q;
        OFS_BURST_SET: bus_rdata = ub_q;
        default:       bus_rdata = '0;
      endcase
    end
  end

  req_qualifier #(.CHANS(CHANS)) u_qual (
    .clk(clk), .rst_n(rst_n_int),
    .mask(mask_q), .enable(en_q), .burst_only(ub_q),
    .single_req(periph_single), .burst_req(periph_burst), .sw_req(sw_req),
    .req_o(chan_req)
  );

  // R6
  clear_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (rd_acc && (bus_addr == OFS_MASK_CLR || bus_addr == OFS_EN_CLR || bus_addr == OFS_BURST_CLR))
      |-> (bus_rdata == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (chan_req == '0));
endmodule

// File: tb/tb_dma_req_gate.sv
`timescale 1ns/1ps
module tb_dma_req_gate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] periph_single, periph_burst, sw_req, en_clr_pulse, chan_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  dma_req_gate dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .periph_single(periph_single), .periph_burst(periph_burst), .sw_req(sw_req),
    .en_clr_pulse(en_clr_pulse), .chan_req(chan_req)
  );

  typedef struct packed {
    logic [31:0] mask, en, ub, single, burst, sw, expect_req;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{32'hAAAAAAAA, 32'hCCCCCCCC, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFFF0000, 32'h00000000, 32'h44440400},
    '{32'hAAAAAAAA, 32'hCCCCCCCC, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFFF0000, 32'hFFFFFFFF, 32'hCCCCCCCC},
    '{32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'h0000FFFF, 32'h00FF0000, 32'h00000000, 32'h00FFFFFF},
    '{32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0000FFFF, 32'h00FF0000, 32'h00000000, 32'h00FF0000},
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12345678, 32'h12345678},
    '{32'h00000000, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_write = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    @(posedge clk);
    #1;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
    periph_single = '0; periph_burst = '0; sw_req = '0; en_clr_pulse = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    bus_rd(8'h20, rd); check("R1 mask", rd, 32'h0);
    bus_rd(8'h28, rd); check("R1 enable", rd, 32'h0);
    bus_rd(8'h18, rd); check("R1 burst-only", rd, 32'h0);
    periph_single = '1; periph_burst = '1; sw_req = '1;
    #1 check("R1 chan_req", chan_req, 32'h0);
    periph_single = '0; periph_burst = '0; sw_req = '0;

    // table walk
    for (int i = 0; i < 6; i++) begin
      bus_wr(8'h24, '1); bus_wr(8'h2C, '1); bus_wr(8'h1C, '1);
      bus_wr(8'h20, VECS[i].mask); bus_wr(8'h28, VECS[i].en); bus_wr(8'h18, VECS[i].ub);
      bus_rd(8'h20, rd); check("R2 mask readback", rd, VECS[i].mask);
      bus_rd(8'h28, rd); check("R4 enable readback", rd, VECS[i].en);
      bus_rd(8'h18, rd); check("R5 burst-only readback", rd, VECS[i].ub);
      @(negedge clk);
      periph_single = VECS[i].single; periph_burst = VECS[i].burst; sw_req = VECS[i].sw;
      #1 check("R8 R9 R10 qualified vector", chan_req, VECS[i].expect_req);
      periph_single = '0; periph_burst = '0; sw_req = '0;
    end

    // R3 zero writes and partial clear
    bus_wr(8'h20, '1);
    bus_wr(8'h20, 32'h0);
    bus_wr(8'h24, 32'h0);
    bus_rd(8'h20, rd); check("R3 zero writes keep mask", rd, 32'hFFFFFFFF);
    bus_wr(8'h24, 32'h0000000F);
    bus_rd(8'h20, rd); check("R3 partial clear", rd, 32'hFFFFFFF0);

    // R4 enable clear address
    bus_wr(8'h28, '1);
    bus_wr(8'h2C, 32'hFFFF0000);
    bus_rd(8'h28, rd); check("R4 enable clear", rd, 32'h0000FFFF);

    // R5 burst-only clear address
    bus_wr(8'h18, '1);
    bus_wr(8'h1C, 32'h0F0F0F0F);
    bus_rd(8'h18, rd); check("R5 burst-only clear", rd, 32'hF0F0F0F0);

    // R6 write-only and unmapped reads
    bus_rd(8'h24, rd); check("R6 mask clear read", rd, 32'h0);
    bus_rd(8'h2C, rd); check("R6 enable clear read", rd, 32'h0);
    bus_rd(8'h1C, rd); check("R6 burst clear read", rd, 32'h0);
    bus_rd(8'h00, rd); check("R6 unmapped 0x00", rd, 32'h0);
    bus_rd(8'hFC, rd); check("R6 unmapped 0xFC", rd, 32'h0);

    // R7 pulse clear and race against set
    bus_wr(8'h2C, '1);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h000000FF;
    en_clr_pulse = 32'h0000000F;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_write = 1'b0; bus_wdata = '0; en_clr_pulse = '0;
    bus_rd(8'h28, rd); check("R7 clear wins over set", rd, 32'h000000F0);
    @(negedge clk); en_clr_pulse = 32'h00000030;
    @(posedge clk); #1 en_clr_pulse = '0;
    bus_rd(8'h28, rd); check("R7 pulse alone", rd, 32'h000000C0);

    // R11 timing of a write against chan_req
    bus_wr(8'h24, '1); bus_wr(8'h28, '1); bus_wr(8'h1C, '1);
    @(negedge clk);
    periph_single = '1;
    #0.5 check("R11 combinational follow", chan_req, 32'hFFFFFFFF);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 8'h20; bus_wdata = '1;
    #1 check("R11 before capture edge", chan_req, 32'hFFFFFFFF);
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    check("R11 after capture edge", chan_req, 32'h0);
    periph_single = '0;

    done = 1;
    finish_run();
  end
endmodule